// File: doc/BRIEF.md
# Priority Pin-Function Mux Resolver

This block decides, for each of a small set of pads, which internal signal drives the pad. Every pad has up to five ranked signal levels, with level 0 the strongest. A level is switched on by a logic condition made of bit-field comparisons against a bank of writable control registers and a read-only strap register. The lowest-numbered level whose condition holds takes the pad. When no level holds, the pad carries its fallback signal. That fallback is not necessarily a GPIO, and a GPIO can itself sit at a ranked level.

Each level condition is an OR of up to three product terms. Each term is an AND of up to three field comparisons. A comparison masks a register, shifts the masked field down to bit 0 by the position of the lowest set mask bit, and compares the result with a right-aligned required value. The condition table is computed at elaboration time from a package function, so every comparator is a constant mask and constant value.

Software writes the four control registers through a plain single-cycle write/read port. The strap register copies the strap pins during every reset cycle and holds the value from the last reset cycle afterwards. This port carries configuration rather than a data stream, so it has no valid/ready handshake. Selection is combinational from register contents.

Top module: `pinmux_prio_resolver`

## Requirements
- R1: While reset is active all four control registers clear to zero, and after reset every pad shows the level implied by all-zero controls and the captured strap value.
- R2: A write with `wr_en_i` high to address 0..3 stores `wdata_i` in that control register. `rdata_o` returns the register addressed by `addr_i` combinationally, and addresses 5..7 read as zero.
- R3: The strap register at address 4 copies `strap_i` on every clock edge while reset is active and holds after release. Writes to address 4 are ignored, and reads of it return the captured value.
- R4: Each pad selects the lowest-numbered level whose condition is true. If none is true, it selects the fallback, encoded as level 5 on `pad_lvl_o` (3 bits per pad, pad p at bits [3p+2:3p]). `pad_sel_o` is one-hot per pad, 6 bits per pad, with bit 5 meaning fallback.
- R5: A comparison takes (register & mask), shifts it right by the mask's lowest set bit, and tests equality with the right-aligned value. On pad 6, level 4 requires ctrl1[10:9] == 1, so ctrl1[10:9] values of 2 and 3 do not enable it.
- R6: A level holds when any of its terms holds. Pad 2 level 0 is ctrl0[12]==1 OR strap[14]==1.
- R7: A level that depends on the strap cannot be turned off by register writes. With strap[14]=1, pad 2 stays at level 0 whatever ctrl0 holds.
- R8: The video mode field is ctrl2[5:4] (0 off, 1/2/3 video widths).
  - Pad 4: level 0 needs mode != 0 AND ctrl3[17]; level 1 (UART) needs ctrl3[17] only.
  - Pad 5: level 0 needs mode == 3 AND ctrl3[22]; level 1 needs ctrl3[22].
- R9: On pad 3, ctrl1[3] and ctrl0[15] must both be 1. Then ctrl2[31]=0 selects level 0 (external reset) and ctrl2[31]=1 selects level 1 (SPI chip select). Otherwise the pad falls back.
- R10: `pad_o[p]` and `pad_oe_o[p]` equal the candidate bits `cand_o_i[6p+k]` and `cand_oe_i[6p+k]`, where k is the selected level (5 for fallback).
- R11: A selection change caused by a write is visible on the outputs right after the clock edge that accepts the write, and not before it.
- R12: Pad 6 uses levels 0, 1, 2 and 4 with level 3 empty.
  - Level 0 (a GPIO) is ctrl1[0]==1.
  - Level 1 is strap[6]==0.
  - Level 2 is ctrl1[1]==1.
  - Level 4 is as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap copied while low |
| strap_i | input | 32 | Strap pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address (0..3 control, 4 strap) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| cand_o_i | input | 42 | Candidate output values, 6 per pad, index = level |
| cand_oe_i | input | 42 | Candidate output enables, 6 per pad |
| pad_sel_o | output | 42 | One-hot selection, 6 bits per pad |
| pad_lvl_o | output | 21 | Encoded selected level, 3 bits per pad |
| pad_o | output | 7 | Routed pad output |
| pad_oe_o | output | 7 | Routed pad output enable |

## Verification
The bench checks the corner cases of each condition and compares every pad against an independent model after each random write.
- Strap-held levels: writes to ctrl0 and to the strap address must leave pad 2 at level 0. A design that let the strap be overwritten would drop pad 2 to fallback.
- Shared enable bit: sweeping the video mode with the same per-pad bit must flip pads 4 and 5 between video and UART at exactly mode 1 and mode 3. A design that mishandled the shared bit would show UART while video is active.
- Shift-then-compare: ctrl1[10:9] values 2 and 3 must not enable pad 6 level 4. Comparing the unshifted field would accept the wrong values.
- Latency: the selection is sampled just before and just after the write edge. A design that registered the selection would lag one cycle; one that forwarded the write data would change too early.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int DW        = 32;
  localparam int NCTRL     = 4;
  localparam int NREG      = NCTRL + 1;
  localparam int STRAP_IDX = NCTRL;
  localparam int NPADS     = 7;
  localparam int NLVL      = 5;
  localparam int NTERM     = 3;
  localparam int NDESC     = 3;
  localparam int LW        = $clog2(NLVL + 1);

  typedef struct packed {
    logic          used;
    logic [2:0]    src;
    logic [DW-1:0] mask;
    logic [DW-1:0] val;
  } desc_t;

  function automatic desc_t fld(int src, logic [DW-1:0] mask, logic [DW-1:0] val);
    desc_t r;
    r.used = 1'b1;
    r.src  = 3'(src);
    r.mask = mask;
    r.val  = val;
    return r;
  endfunction

  function automatic desc_t one_bit(int src, int b, int v);
    return fld(src, DW'(1) << b, DW'(v));
  endfunction

  function automatic int mask_lsb(logic [DW-1:0] m);
    int r = 0;
    for (int i = DW - 1; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  // Condition table: pad, level, term, descriptor slot.
  function automatic desc_t lookup(int pad, int lvl, int term, int d);
    desc_t r = '0;
    case (pad * 1000 + lvl * 100 + term * 10 + d)
      0000: r = one_bit(0, 0, 1);
      1000: r = one_bit(2, 22, 1);
      1100: r = one_bit(0, 4, 1);
      2000: r = one_bit(0, 12, 1);
      2010: r = one_bit(STRAP_IDX, 14, 1);
      3000: r = one_bit(1, 3, 1);
      3001: r = one_bit(0, 15, 1);
      3002: r = one_bit(2, 31, 0);
      3100: r = one_bit(1, 3, 1);
      3101: r = one_bit(0, 15, 1);
      3102: r = one_bit(2, 31, 1);
      4000: r = fld(2, 32'h30, 32'd1);
      4001: r = one_bit(3, 17, 1);
      4010: r = fld(2, 32'h30, 32'd2);
      4011: r = one_bit(3, 17, 1);
      4020: r = fld(2, 32'h30, 32'd3);
      4021: r = one_bit(3, 17, 1);
      4100: r = one_bit(3, 17, 1);
      5000: r = fld(2, 32'h30, 32'd3);
      5001: r = one_bit(3, 22, 1);
      5100: r = one_bit(3, 22, 1);
      6000: r = one_bit(1, 0, 1);
      6100: r = one_bit(STRAP_IDX, 6, 0);
      6200: r = one_bit(1, 1, 1);
      6400: r = fld(1, 32'h600, 32'd1);
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pmx_regfile.sv
module pmx_regfile
  import pmx_pkg::*;
#(
  parameter int N_CTRL = NCTRL,
  parameter int AW     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            strap_i,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [(N_CTRL+1)*DW-1:0] bank_o
);
  localparam int NR = N_CTRL + 1;

  logic [DW-1:0] ctrl_q [N_CTRL];
  logic [DW-1:0] strap_q;

  for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n)
        ctrl_q[i] <= '0;
      else if (wr_en_i && int'(addr_i) == i)
        ctrl_q[i] <= wdata_i;
    end
    assign bank_o[i*DW +: DW] = ctrl_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end
  assign bank_o[N_CTRL*DW +: DW] = strap_q;

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < NR) rdata_o = bank_o[int'(addr_i)*DW +: DW];
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(addr_i) < N_CTRL) |=> (bank_o[$past(int'(addr_i))*DW +: DW] == $past(wdata_i)));

  a_r3_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> $stable(strap_q));
endmodule

// File: rtl/pmx_level_eval.sv
module pmx_level_eval
  import pmx_pkg::*;
#(
  parameter int PAD = 0,
  parameter int LVL = 0
) (
  input  logic [NREG*DW-1:0] bank_i,
  output logic               hit_o
);
  logic [NTERM-1:0] term_ok;

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    logic [NDESC-1:0] cmp;
    logic [NDESC-1:0] used;
    for (genvar d = 0; d < NDESC; d++) begin : g_desc
      localparam desc_t D   = lookup(PAD, LVL, t, d);
      localparam int    SH  = mask_lsb(D.mask);
      localparam int    SRC = int'(D.src);
      assign used[d] = D.used;
      if (D.used) begin : g_on
        assign cmp[d] = (((bank_i[SRC*DW +: DW] & D.mask) >> SH) == D.val);
      end else begin : g_off
        assign cmp[d] = 1'b1;
      end
    end
    assign term_ok[t] = (|used) & (&cmp);
  end

  assign hit_o = |term_ok;
endmodule

// File: rtl/pmx_pad_resolve.sv
module pmx_pad_resolve
  import pmx_pkg::*;
#(
  parameter int PAD = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREG*DW-1:0]   bank_i,
  input  logic [NLVL:0]        cand_o_i,
  input  logic [NLVL:0]        cand_oe_i,
  output logic [NLVL:0]        sel_o,
  output logic [LW-1:0]        lvl_o,
  output logic                 pad_o,
  output logic                 pad_oe_o
);
  logic [NLVL-1:0] hit;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    pmx_level_eval #(.PAD(PAD), .LVL(l)) i_eval (
      .bank_i (bank_i),
      .hit_o  (hit[l])
    );
  end

  always_comb begin
    sel_o       = '0;
    sel_o[NLVL] = 1'b1;
    lvl_o       = LW'(NLVL);
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (hit[l]) begin
        sel_o    = '0;
        sel_o[l] = 1'b1;
        lvl_o    = LW'(l);
      end
    end
  end

  assign pad_o    = |(sel_o & cand_o_i);
  assign pad_oe_o = |(sel_o & cand_oe_i);

  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_o) == 1);
  a_r4_top_level_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> sel_o[0]);
  a_r4_fallback_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o[NLVL] |-> (hit == '0));
endmodule

// File: rtl/pinmux_prio_resolver.sv
module pinmux_prio_resolver
  import pmx_pkg::*;
#(
  parameter int N_PADS = NPADS,
  parameter int AW     = 3,
  localparam int NC    = N_PADS * (NLVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      strap_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NC-1:0]      cand_o_i,
  input  logic [NC-1:0]      cand_oe_i,
  output logic [NC-1:0]      pad_sel_o,
  output logic [N_PADS*LW-1:0] pad_lvl_o,
  output logic [N_PADS-1:0]  pad_o,
  output logic [N_PADS-1:0]  pad_oe_o
);
  logic [NREG*DW-1:0] bank;

  pmx_regfile #(.N_CTRL(NCTRL), .AW(AW)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .bank_o  (bank)
  );

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    pmx_pad_resolve #(.PAD(p)) i_pad (
      .clk       (clk),
      .rst_n     (rst_n),
      .bank_i    (bank),
      .cand_o_i  (cand_o_i[p*(NLVL+1) +: NLVL+1]),
      .cand_oe_i (cand_oe_i[p*(NLVL+1) +: NLVL+1]),
      .sel_o     (pad_sel_o[p*(NLVL+1) +: NLVL+1]),
      .lvl_o     (pad_lvl_o[p*LW +: LW]),
      .pad_o     (pad_o[p]),
      .pad_oe_o  (pad_oe_o[p])
    );
  end
endmodule

// File: tb/test_pinmux_prio_resolver.sv
module test_pinmux_prio_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strap_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [41:0] cand_o_i = '0;
  logic [41:0] cand_oe_i = '0;
  logic [41:0] pad_sel_o;
  logic [20:0] pad_lvl_o;
  logic [6:0]  pad_o;
  logic [6:0]  pad_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] cm [4];
  logic [31:0] sm;

  always #5 clk = ~clk;

  pinmux_prio_resolver i_pinmux_prio_resolver (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .cand_o_i(cand_o_i), .cand_oe_i(cand_oe_i), .pad_sel_o(pad_sel_o),
    .pad_lvl_o(pad_lvl_o), .pad_o(pad_o), .pad_oe_o(pad_oe_o)
  );

  function automatic int exp_lvl(int p);
    logic [1:0] vm = cm[2][5:4];
    case (p)
      0: return cm[0][0] ? 0 : 5;
      1: return cm[2][22] ? 0 : (cm[0][4] ? 1 : 5);
      2: return (cm[0][12] || sm[14]) ? 0 : 5;
      3: return (cm[1][3] && cm[0][15]) ? (cm[2][31] ? 1 : 0) : 5;
      4: return (vm != 0 && cm[3][17]) ? 0 : (cm[3][17] ? 1 : 5);
      5: return (vm == 3 && cm[3][22]) ? 0 : (cm[3][22] ? 1 : 5);
      default: begin
        if (cm[1][0]) return 0;
        if (!sm[6]) return 1;
        if (cm[1][1]) return 2;
        if (cm[1][10:9] == 2'd1) return 4;
        return 5;
      end
    endcase
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_pad(string tag, int p, int exp);
    chk(tag, $sformatf("pad%0d level", p), pad_lvl_o[p*3 +: 3], exp);
  endtask

  task automatic chk_all(string tag);
    for (int p = 0; p < 7; p++) begin
      int e = exp_lvl(p);
      chk(tag, $sformatf("pad%0d level", p), pad_lvl_o[p*3 +: 3], e);
      chk(tag, $sformatf("pad%0d sel", p), pad_sel_o[p*6 +: 6], 6'(1) << e);
      chk("R10", $sformatf("pad%0d out", p), pad_o[p], cand_o_i[p*6 + e]);
      chk("R10", $sformatf("pad%0d oe", p), pad_oe_o[p], cand_oe_i[p*6 + e]);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 3'(a); wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (a < 4) cm[a] = d;
  endtask

  task automatic rd_chk(string tag, int a, logic [31:0] exp);
    addr_i = 3'(a);
    #1;
    chk(tag, $sformatf("read addr %0d", a), rdata_o, exp);
  endtask

  task automatic do_reset(logic [31:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap_i = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    strap_i = ~s;
    for (int i = 0; i < 4; i++) cm[i] = '0;
    sm = s;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(32'h0000_4040);
    // R1 reset state
    for (int i = 0; i < 4; i++) rd_chk("R1", i, 32'h0);
    chk_all("R1");
    // R3 strap capture and write ignore
    rd_chk("R3", 4, 32'h0000_4040);
    wr(4, 32'hFFFF_BFBF);
    rd_chk("R3", 4, 32'h0000_4040);
    chk_pad("R3", 2, 0);
    chk_pad("R3", 6, 5);
    // R2 read of unmapped addresses
    rd_chk("R2", 5, 32'h0);
    rd_chk("R2", 7, 32'h0);
    // R7 strap term cannot be cleared
    wr(0, 32'h0000_0000);
    chk_pad("R7", 2, 0);
    wr(0, 32'hFFFF_EFFF);
    chk_pad("R7", 2, 0);
    rd_chk("R2", 0, 32'hFFFF_EFFF);
    wr(0, 32'h0);
    // R9 chip-select / external reset pad
    wr(1, 32'h8); chk_pad("R9", 3, 5);
    wr(0, 32'h8000); chk_pad("R9", 3, 0);
    wr(2, 32'h8000_0000); chk_pad("R9", 3, 1);
    wr(1, 32'h0); chk_pad("R9", 3, 5);
    // R8 video mode sweep
    wr(3, 32'h0042_0000);
    wr(2, 32'h00); chk_pad("R8", 4, 1); chk_pad("R8", 5, 1);
    wr(2, 32'h10); chk_pad("R8", 4, 0); chk_pad("R8", 5, 1);
    wr(2, 32'h20); chk_pad("R8", 4, 0); chk_pad("R8", 5, 1);
    wr(2, 32'h30); chk_pad("R8", 4, 0); chk_pad("R8", 5, 0);
    wr(3, 32'h0); chk_pad("R8", 4, 5); chk_pad("R8", 5, 5);
    // R5 / R12 pad with five levels and a gap
    wr(1, 32'h200); chk_pad("R5", 6, 4);
    wr(1, 32'h400); chk_pad("R5", 6, 5);
    wr(1, 32'h600); chk_pad("R5", 6, 5);
    wr(1, 32'h202); chk_pad("R12", 6, 2);
    wr(1, 32'h203); chk_pad("R12", 6, 0);
    // R4 priority on pad 1
    wr(0, 32'h10); chk_pad("R4", 1, 1);
    wr(2, 32'h0040_0000); chk_pad("R4", 1, 0);
    // R6 OR through control bit with strap also set
    wr(0, 32'h1000); chk_pad("R6", 2, 0);
    // R11 latency on pad 0
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 3'd0; wdata_i = 32'h1;
    #1 chk_pad("R11", 0, 5);
    @(posedge clk); #1;
    wr_en_i = 1'b0; cm[0] = 32'h1;
    chk_pad("R11", 0, 0);
    // Random mix
    for (int it = 0; it < 400; it++) begin
      int a = $urandom_range(0, 4);
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 1) == 0) d = d & 32'h8066_9633;
      cand_o_i  = {10'($urandom), $urandom};
      cand_oe_i = {10'($urandom), $urandom};
      wr(a, d);
      chk_all("R4");
    end
    // Second reset with other strap: R3 and R12 level 1
    do_reset(32'h0000_0000);
    rd_chk("R3", 4, 32'h0);
    chk_pad("R12", 6, 1);
    chk_pad("R6", 2, 5);
    chk_all("R1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule